// File: doc/BRIEF.md
# Color Palette Host Access Controller

This block gives a host processor access to a 256-entry color lookup table with 30-bit entries (10 bits each for red, green and blue), plus a small bank of configuration registers. The host uses a simple synchronous parallel bus: a one-cycle strobe, two select lines, a read/write line and a 10-bit data path. Two of the four select codes reach the address register and the mode register directly. A third reaches the control register that the address register currently indexes. The fourth reaches the palette.

Palette entries are loaded and read one color component per strobe. An internal color pointer walks red, green, blue. Red and green writes are held in staging registers, and the whole entry is committed in one step on the blue write. A read of red captures the full entry into a read-ahead latch, and green and blue are then served from that latch. After every blue access the address register steps forward and wraps at the top of the table. Bit 0 of the mode register selects an 8-bit data path, in which each component travels as its upper 8 bits. A second, independent port lets the pixel path look up entries every cycle.

Top module: `cpal_host_ctrl`

## Requirements
- R1: After synchronous reset the address register, mode register, control registers, color pointer and `hst_rdata` are all zero, and the pointer starts at red.
- R2: Select code 00 reads and writes the address register, and select code 11 reads and writes the 10-bit mode register. Both are accessed directly, and writing the mode register does not change the address register.
- R3: Select code 10 accesses the control register whose index equals the address register. A write to an index at or above `NUM_CTRL` changes nothing, and a read of such an index returns zero.
- R4: Palette writes (select 01) stage red, then green. The blue write stores the word {red[29:20], green[19:10], blue[9:0]} at the addressed entry. The entry is unchanged until that blue write.
- R5: The address register increments by one after each blue palette read or write, and wraps from the last entry (FFh) to 00h.
- R6: A write to the address register returns the color pointer to red, so a partly staged entry is abandoned.
- R7: Three palette reads return red, green and blue of the addressed entry. Green and blue come from the copy captured at the red read.
- R8: With mode bit 0 set (8-bit path), a written component is data[7:0] followed by two zero bits, and data[9:8] are ignored. A read returns the upper 8 bits of the component in `hst_rdata[7:0]`, with bits 9:8 zero. With mode bit 0 clear, all 10 bits pass unchanged.
- R9: `pix_color` shows the table entry at `pix_idx` one clock after `pix_idx` is sampled.
- R10: `hst_rdata` is loaded only on the clock edge that samples a read strobe, and it holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_ce | input | 1 | Host access strobe, one cycle per access |
| hst_rd | input | 1 | 1 = read, 0 = write |
| hst_sel | input | 2 | Register select: 00 address, 01 palette, 10 control, 11 mode |
| hst_wdata | input | 10 | Host write data |
| hst_rdata | output | 10 | Host read data, registered |
| pix_idx | input | ADDR_W | Pixel-side table index |
| pix_color | output | 30 | Pixel-side table entry {R,G,B} |
| mode_out | output | 10 | Current mode register |
| ctrl_out | output | NUM_CTRL*CTRL_W | All control registers, index 0 in the low bits |

## Verification
The bench builds the block with `ADDR_W` = 8, `CTRL_W` = 10 and `NUM_CTRL` = 4. The full 8-bit address therefore makes the FFh-to-00h wrap reachable through a single address write. The small control bank leaves indices 4 to 255 unused, so the bench can show that a write to an unused index is ignored and reads back as zero. Both bus widths are exercised through the same palette entries. The pixel port is used to look at the table after the red, green and blue writes, which shows that nothing is committed before the blue write.

// File: rtl/cpal_pkg.sv
package cpal_pkg;
    localparam int COMP_W = 10;
    localparam int WORD_W = 3 * COMP_W;
    localparam int NARROW_W = 8;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'b00,
        SEL_PAL  = 2'b01,
        SEL_CTRL = 2'b10,
        SEL_MODE = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        PTR_RED = 2'b00,
        PTR_GRN = 2'b01,
        PTR_BLU = 2'b10
    } ptr_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic              ce;
        logic              rd;
        sel_e              sel;
        logic [COMP_W-1:0] wdata;
    } hreq_t;

    // bus value -> stored component
    function automatic logic [COMP_W-1:0] comp_in(input logic [COMP_W-1:0] d, input logic narrow);
        return narrow ? {d[NARROW_W-1:0], {(COMP_W-NARROW_W){1'b0}}} : d;
    endfunction

    // stored component -> bus value
    function automatic logic [COMP_W-1:0] comp_out(input logic [COMP_W-1:0] c, input logic narrow);
        return narrow ? {{(COMP_W-NARROW_W){1'b0}}, c[COMP_W-1:COMP_W-NARROW_W]} : c;
    endfunction
endpackage

// File: rtl/cpal_regs.sv
module cpal_regs
    import cpal_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_CTRL = 4,
    parameter int CTRL_W   = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  hreq_t                      req,
    input  logic                       addr_inc,
    output logic [ADDR_W-1:0]          addr_q,
    output logic                       addr_wr,
    output logic [COMP_W-1:0]          mode_q,
    output logic [NUM_CTRL*CTRL_W-1:0] ctrl_flat,
    output logic [COMP_W-1:0]          rd_direct
);
    logic [NUM_CTRL-1:0][CTRL_W-1:0] ctrl_q;
    logic [CTRL_W-1:0]               ctrl_rd;
    logic                            wr_any;

    assign wr_any  = req.ce && !req.rd;
    assign addr_wr = wr_any && (req.sel == SEL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mode_q <= '0;
        end else begin
            if (addr_wr)
                addr_q <= req.wdata[ADDR_W-1:0];
            else if (addr_inc)
                addr_q <= addr_q + 1'b1;
            if (wr_any && req.sel == SEL_MODE)
                mode_q <= req.wdata;
        end
    end

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst)
                ctrl_q[i] <= '0;
            else if (wr_any && req.sel == SEL_CTRL && addr_q == ADDR_W'(i))
                ctrl_q[i] <= req.wdata[CTRL_W-1:0];
        end
    end

    always_comb begin
        ctrl_rd = '0;
        for (int i = 0; i < NUM_CTRL; i++)
            if (addr_q == ADDR_W'(i)) ctrl_rd = ctrl_q[i];
    end

    always_comb begin
        case (req.sel)
            SEL_ADDR: rd_direct = COMP_W'(addr_q);
            SEL_MODE: rd_direct = mode_q;
            SEL_CTRL: rd_direct = COMP_W'(ctrl_rd);
            default:  rd_direct = '0;
        endcase
    end

    assign ctrl_flat = ctrl_q;
endmodule

// File: rtl/cpal_stage.sv
module cpal_stage
    import cpal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hreq_t             req,
    input  logic              narrow,
    input  logic              addr_wr,
    input  rgb_t              lut_word,
    output ptr_e              ptr_q,
    output logic              lut_we,
    output rgb_t              lut_wword,
    output logic              addr_inc,
    output logic [COMP_W-1:0] pal_rdata
);
    logic              pal_acc;
    logic [COMP_W-1:0] comp_w;
    logic [COMP_W-1:0] st_r, st_g;
    logic [COMP_W-1:0] ahead_g, ahead_b;

    assign pal_acc  = req.ce && (req.sel == SEL_PAL);
    assign comp_w   = comp_in(req.wdata, narrow);
    assign addr_inc = pal_acc && (ptr_q == PTR_BLU);
    assign lut_we   = addr_inc && !req.rd;
    assign lut_wword = '{r: st_r, g: st_g, b: comp_w};

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= PTR_RED;
            st_r    <= '0;
            st_g    <= '0;
            ahead_g <= '0;
            ahead_b <= '0;
        end else if (addr_wr) begin
            ptr_q <= PTR_RED;
        end else if (pal_acc) begin
            case (ptr_q)
                PTR_RED: begin
                    ptr_q <= PTR_GRN;
                    if (req.rd) begin
                        ahead_g <= lut_word.g;
                        ahead_b <= lut_word.b;
                    end else begin
                        st_r <= comp_w;
                    end
                end
                PTR_GRN: begin
                    ptr_q <= PTR_BLU;
                    if (!req.rd) st_g <= comp_w;
                end
                default: ptr_q <= PTR_RED;
            endcase
        end
    end

    always_comb begin
        case (ptr_q)
            PTR_RED: pal_rdata = comp_out(lut_word.r, narrow);
            PTR_GRN: pal_rdata = comp_out(ahead_g, narrow);
            default: pal_rdata = comp_out(ahead_b, narrow);
        endcase
    end
endmodule

// File: rtl/cpal_lut.sv
module cpal_lut
    import cpal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  rgb_t              wword,
    output rgb_t              hword,
    input  logic [ADDR_W-1:0] pix_idx,
    output rgb_t              pix_word
);
    localparam int DEPTH = 1 << ADDR_W;

    rgb_t mem [DEPTH];

    always_ff @(posedge clk)
        if (we) mem[addr] <= wword;

    assign hword = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) pix_word <= '0;
        else     pix_word <= mem[pix_idx];
    end
endmodule

// File: rtl/cpal_host_ctrl.sv
module cpal_host_ctrl
    import cpal_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_CTRL = 4,
    parameter int CTRL_W   = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hst_ce,
    input  logic                       hst_rd,
    input  logic [1:0]                 hst_sel,
    input  logic [9:0]                 hst_wdata,
    output logic [9:0]                 hst_rdata,
    input  logic [ADDR_W-1:0]          pix_idx,
    output logic [29:0]                pix_color,
    output logic [9:0]                 mode_out,
    output logic [NUM_CTRL*CTRL_W-1:0] ctrl_out
);
    hreq_t             req;
    logic [ADDR_W-1:0] addr_q;
    logic              addr_wr, addr_inc, lut_we;
    logic [COMP_W-1:0] mode_q, rd_direct, pal_rdata;
    ptr_e              col_ptr;
    rgb_t              lut_hword, lut_wword, pix_word;

    assign req = '{ce: hst_ce, rd: hst_rd, sel: sel_e'(hst_sel), wdata: hst_wdata};

    cpal_regs #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .CTRL_W(CTRL_W)) u_regs (
        .clk(clk), .rst(rst), .req(req), .addr_inc(addr_inc),
        .addr_q(addr_q), .addr_wr(addr_wr), .mode_q(mode_q),
        .ctrl_flat(ctrl_out), .rd_direct(rd_direct)
    );

    cpal_stage u_stage (
        .clk(clk), .rst(rst), .req(req), .narrow(mode_q[0]), .addr_wr(addr_wr),
        .lut_word(lut_hword), .ptr_q(col_ptr), .lut_we(lut_we),
        .lut_wword(lut_wword), .addr_inc(addr_inc), .pal_rdata(pal_rdata)
    );

    cpal_lut #(.ADDR_W(ADDR_W)) u_lut (
        .clk(clk), .rst(rst), .we(lut_we), .addr(addr_q), .wword(lut_wword),
        .hword(lut_hword), .pix_idx(pix_idx), .pix_word(pix_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            hst_rdata <= '0;
        else if (req.ce && req.rd)
            hst_rdata <= (req.sel == SEL_PAL) ? pal_rdata : rd_direct;
    end

    assign pix_color = pix_word;
    assign mode_out  = mode_q;
endmodule

// File: rtl/cpal_host_ctrl_chk.sv
module cpal_host_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce,
    input logic              rd,
    input logic [1:0]        sel,
    input logic [9:0]        rdata,
    input logic [1:0]        ptr,
    input logic [ADDR_W-1:0] addr
);
    // R6: an address write sends the pointer back to red
    a_r6_ptr_home: assert property (@(posedge clk) disable iff (rst)
        (ce && !rd && sel == 2'b00) |=> (ptr == 2'b00));

    // R5: blue palette access steps the address, wrapping naturally
    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        (ce && sel == 2'b01 && ptr == 2'b10) |=> (addr == $past(addr) + 1'b1));

    // R4: red access moves on to green, green to blue
    a_r4_red_to_grn: assert property (@(posedge clk) disable iff (rst)
        (ce && sel == 2'b01 && ptr == 2'b00) |=> (ptr == 2'b01));
    a_r4_grn_to_blu: assert property (@(posedge clk) disable iff (rst)
        (ce && sel == 2'b01 && ptr == 2'b01) |=> (ptr == 2'b10));

    // R10: read data moves only on a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !(ce && rd) |=> $stable(rdata));

    // R2: address register is quiet without a strobe
    a_r2_addr_quiet: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(addr));

    // R1: pointer never takes the unused code
    a_r1_ptr_legal: assert property (@(posedge clk) disable iff (rst)
        ptr != 2'b11);
endmodule

bind cpal_host_ctrl cpal_host_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .ce(hst_ce), .rd(hst_rd), .sel(hst_sel),
    .rdata(hst_rdata), .ptr(col_ptr), .addr(addr_q)
);

// File: tb/cpal_host_ctrl_bench.sv
module cpal_host_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int NUM_CTRL = 4;
    localparam int CTRL_W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hst_ce = 1'b0, hst_rd = 1'b0;
    logic [1:0] hst_sel = 2'b00;
    logic [9:0] hst_wdata = '0;
    logic [9:0] hst_rdata;
    logic [ADDR_W-1:0] pix_idx = '0;
    logic [29:0] pix_color;
    logic [9:0] mode_out;
    logic [NUM_CTRL*CTRL_W-1:0] ctrl_out;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpal_host_ctrl #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .CTRL_W(CTRL_W)) u_cpal_host_ctrl (
        .clk(clk), .rst(rst), .hst_ce(hst_ce), .hst_rd(hst_rd), .hst_sel(hst_sel),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .pix_idx(pix_idx),
        .pix_color(pix_color), .mode_out(mode_out), .ctrl_out(ctrl_out)
    );

    function automatic logic [29:0] pk(input logic [9:0] r, input logic [9:0] g, input logic [9:0] b);
        return {r, g, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [9:0] d);
        @(negedge clk);
        hst_ce = 1'b1; hst_rd = 1'b0; hst_sel = sel; hst_wdata = d;
        @(negedge clk);
        hst_ce = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] sel, output logic [9:0] d);
        @(negedge clk);
        hst_ce = 1'b1; hst_rd = 1'b1; hst_sel = sel;
        @(negedge clk);
        hst_ce = 1'b0; hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    task automatic pix_look(input logic [ADDR_W-1:0] idx, output logic [29:0] w);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        w = pix_color;
    endtask

    task automatic t_reset;
        logic [9:0] d;
        chk("R1 rdata", 32'(hst_rdata), 0);
        chk("R1 mode", 32'(mode_out), 0);
        chk("R1 ctrl", 32'(ctrl_out), 0);
        bus_rd(2'b00, d); chk("R1 addr", 32'(d), 0);
    endtask

    task automatic t_direct;
        logic [9:0] d;
        bus_wr(2'b00, 10'h05A);
        bus_wr(2'b11, 10'h3A4);
        bus_rd(2'b00, d); chk("R2 addr rw", 32'(d), 32'h5A);
        bus_rd(2'b11, d); chk("R2 mode rw", 32'(d), 32'h3A4);
        bus_wr(2'b11, 10'h000);
        chk("R2 mode out", 32'(mode_out), 0);
    endtask

    task automatic t_ctrl;
        logic [9:0] d;
        bus_wr(2'b00, 10'd2); bus_wr(2'b10, 10'h23C);
        bus_wr(2'b00, 10'd3); bus_wr(2'b10, 10'h081);
        bus_wr(2'b00, 10'd9); bus_wr(2'b10, 10'h3FF);
        bus_rd(2'b10, d); chk("R3 unused reads zero", 32'(d), 0);
        chk("R3 unused write ignored", 32'(ctrl_out), 32'({10'h081, 10'h23C, 10'h0, 10'h0}));
        bus_wr(2'b00, 10'd2);
        bus_rd(2'b10, d); chk("R3 indirect read", 32'(d), 32'h23C);
    endtask

    task automatic t_pal_write;
        logic [29:0] w;
        logic [9:0] d;
        bus_wr(2'b00, 10'h10);
        bus_wr(2'b01, 10'h3FF);
        bus_wr(2'b01, 10'h155);
        pix_look(8'h10, w); chk("R4 not committed before blue", 32'(w), 0);
        bus_wr(2'b01, 10'h2AA);
        pix_look(8'h10, w); chk("R4 committed word", 32'(w), 32'(pk(10'h3FF, 10'h155, 10'h2AA)));
        chk("R9 pixel lookup", 32'(pix_color), 32'(pk(10'h3FF, 10'h155, 10'h2AA)));
        bus_rd(2'b00, d); chk("R5 increment after blue write", 32'(d), 32'h11);
    endtask

    task automatic t_pal_read;
        logic [9:0] d;
        bus_wr(2'b00, 10'h10);
        bus_rd(2'b01, d); chk("R7 red", 32'(d), 32'h3FF);
        bus_rd(2'b01, d); chk("R7 green", 32'(d), 32'h155);
        bus_wr(2'b11, 10'h000);
        chk("R10 hold over write", 32'(hst_rdata), 32'h155);
        bus_rd(2'b01, d); chk("R7 blue", 32'(d), 32'h2AA);
        bus_rd(2'b00, d); chk("R5 increment after blue read", 32'(d), 32'h11);
    endtask

    task automatic t_wrap;
        logic [9:0] d;
        logic [29:0] w;
        bus_wr(2'b00, 10'hFF);
        bus_wr(2'b01, 10'h001); bus_wr(2'b01, 10'h002); bus_wr(2'b01, 10'h003);
        bus_rd(2'b00, d); chk("R5 wrap to zero", 32'(d), 0);
        pix_look(8'hFF, w); chk("R9 top entry", 32'(w), 32'(pk(10'h1, 10'h2, 10'h3)));
    endtask

    task automatic t_ptr_reset;
        logic [9:0] d;
        logic [29:0] w;
        bus_wr(2'b00, 10'h20);
        bus_wr(2'b01, 10'h011); bus_wr(2'b01, 10'h022);
        bus_wr(2'b00, 10'h20);
        bus_wr(2'b01, 10'h007); bus_wr(2'b01, 10'h008); bus_wr(2'b01, 10'h009);
        pix_look(8'h20, w); chk("R6 restart at red", 32'(w), 32'(pk(10'h7, 10'h8, 10'h9)));
        bus_rd(2'b00, d); chk("R6 single increment", 32'(d), 32'h21);
    endtask

    task automatic t_narrow;
        logic [9:0] d;
        logic [29:0] w;
        bus_wr(2'b11, 10'h001);
        bus_wr(2'b00, 10'h40);
        bus_wr(2'b01, 10'h3AB); bus_wr(2'b01, 10'h0CD); bus_wr(2'b01, 10'h0EF);
        pix_look(8'h40, w); chk("R8 narrow write", 32'(w), 32'(pk(10'h2AC, 10'h334, 10'h3BC)));
        bus_wr(2'b00, 10'h40);
        bus_rd(2'b01, d); chk("R8 narrow red", 32'(d), 32'hAB);
        bus_rd(2'b01, d); chk("R8 narrow green", 32'(d), 32'hCD);
        bus_rd(2'b01, d); chk("R8 narrow blue", 32'(d), 32'hEF);
        bus_wr(2'b11, 10'h000);
        bus_wr(2'b00, 10'h40);
        bus_rd(2'b01, d); chk("R8 wide red", 32'(d), 32'h2AC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_ctrl();
        t_pal_write();
        t_pal_read();
        t_wrap();
        t_ptr_reset();
        t_narrow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule